// File: doc/BRIEF.md
# Touch Sensor Host Link: Full-Duplex Serial Slave with Status Reply

This block is the host-facing serial port of a touch position sensor. While the host lowers the select line and clocks a frame, the block shifts one command byte in from the host and, on the same clock pulses, shifts one status byte back out. The reply never depends on the command. It is built from the touch result of the previous acquisition and is taken at the moment select falls. Because the reply is fixed at that moment, each frame returns the outcome of the burst started by the frame before it, so commands overlap.

The serial clock idles low. Both data lines change after a falling clock edge and are sampled on a rising clock edge, most significant bit first. The serial inputs are brought into the system clock domain by a synchronizer chain. Edges are then detected from the synchronized levels. While the sequencer holds `data_rdy` low, serial clock edges are ignored.

When select rises, the block judges the frame. If the frame held exactly the configured number of counted rising edges, the block pulses `frame_done` for one cycle with the latched command, and the sequencer starts a burst. It also flags the all-zero null command. Any other count pulses `frame_err` instead and leaves the latched command unchanged.

The control machine has four states. IDLE waits for select to fall. IDLE to SHIFT happens on a select fall, which loads the status byte. SHIFT moves to COMMIT on a select rise when the count is exact. SHIFT moves to FAULT on a select rise with any other count. COMMIT and FAULT each return to IDLE after one cycle.

Top module: `touch_spi_slave`

## Requirements
- R1: `miso` changes only after a synchronized select fall (which presents status bit 7) or a counted serial clock fall. It holds steady while the serial clock is high, and `mosi` is taken on counted rising edges.
- R2: In a valid 8-bit frame, the host reads the status byte on `miso` MSB first. The bits sent on `mosi`, MSB first, appear on `cmd_byte` when `frame_done` pulses.
- R3: With `touch_det` low, the status byte is bit 7 = 0, bit 6 = `wheel_type` (0 linear, 1 wheel), and bits 5 to 0 = 0. This includes reserved bits 1 and 0.
- R4: With `touch_det` high, the status byte is bit 7 = 1 and bits 6 to 0 = `touch_pos`.
- R5: The status byte is captured when select falls. Changes to `touch_det`, `wheel_type` or `touch_pos` later in the frame do not alter the bits sent.
- R6: A select rise after exactly 8 counted rising edges pulses `frame_done` for one cycle and updates `cmd_byte`. `cmd_byte` changes at no other time.
- R7: A select rise after any other count of counted rising edges (0, fewer than 8, or more than 8) pulses `frame_err` for one cycle. `frame_done` stays low and `cmd_byte` is unchanged.
- R8: Serial clock edges while `data_rdy` is low are neither counted nor shifted.
- R9: `cmd_is_null` is high together with `frame_done` exactly when the received command is 0x00.
- R10: `frame_done` and `frame_err` are never high together, and each lasts a single cycle.
- R11: After reset, `miso`, `cmd_byte`, `frame_done`, `frame_err` and `cmd_is_null` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock from host, idles low |
| ss_n | input | 1 | Active-low frame select from host |
| mosi | input | 1 | Serial data from host |
| data_rdy | input | 1 | High when the sequencer accepts serial clocking |
| touch_det | input | 1 | Previous acquisition saw a touch |
| wheel_type | input | 1 | Sensor type flag: 0 linear, 1 wheel |
| touch_pos | input | BITS-1 | Position from previous acquisition |
| miso | output | 1 | Serial status data to host |
| cmd_byte | output | BITS | Last valid command received |
| frame_done | output | 1 | One-cycle pulse: valid frame completed |
| frame_err | output | 1 | One-cycle pulse: frame had a wrong edge count |
| cmd_is_null | output | 1 | With `frame_done`: command was 0x00 |

## Verification
Each serial pin change reaches the control logic three system clocks after it is driven: two synchronizer stages, then the edge-detect register, and it is acted on at the third rising edge. `miso` therefore settles three cycles after a serial clock fall or select fall, and `frame_done` or `frame_err` rises three cycles after select rises and lasts one cycle. The bench holds every serial level for six system clocks. It reads `miso` just before raising the serial clock, checks it stays put for the whole high phase, and scans a ten-cycle window after select rises to catch the completion pulse and the command that accompanies it.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_FAULT  = 2'd3
    } link_state_t;

    localparam int DEFAULT_BITS = 8;

endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
    parameter int              STAGES = 2,
    parameter int              WIDTH  = 3,
    parameter logic [WIDTH-1:0] INIT  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] pipe [STAGES];

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= INIT;
                else        pipe[0] <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
                end else begin
                    pipe[0] <= din;
                    for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/tss_status_fmt.sv
module tss_status_fmt #(
    parameter int BITS = 8
) (
    input  logic            touch_det,
    input  logic            wheel_type,
    input  logic [BITS-2:0] touch_pos,
    output logic [BITS-1:0] status
);
    localparam int PAD = BITS - 2;

    always_comb begin
        if (touch_det) status = {1'b1, touch_pos};
        else           status = {1'b0, wheel_type, {PAD{1'b0}}};
    end
endmodule

// File: rtl/tss_shifter.sv
module tss_shifter #(
    parameter int BITS = 8,
    localparam int CW  = $clog2(BITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            shift_en,
    input  logic            out_en,
    input  logic            mosi_bit,
    output logic [BITS-1:0] shreg,
    output logic            miso,
    output logic [CW-1:0]   cnt,
    output logic            over
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
            over  <= 1'b0;
        end else if (load) begin
            shreg <= load_val;
            cnt   <= '0;
            over  <= 1'b0;
        end else if (shift_en) begin
            shreg <= {shreg[BITS-2:0], mosi_bit};
            if (cnt == CW'(BITS)) over <= 1'b1;
            else                  cnt  <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      miso <= 1'b0;
        else if (load)   miso <= load_val[BITS-1];
        else if (out_en) miso <= shreg[BITS-1];
    end
endmodule

// File: rtl/touch_spi_slave.sv
module touch_spi_slave
    import tss_pkg::*;
#(
    parameter int BITS        = DEFAULT_BITS,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = $clog2(BITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck,
    input  logic            ss_n,
    input  logic            mosi,
    input  logic            data_rdy,
    input  logic            touch_det,
    input  logic            wheel_type,
    input  logic [BITS-2:0] touch_pos,
    output logic            miso,
    output logic [BITS-1:0] cmd_byte,
    output logic            frame_done,
    output logic            frame_err,
    output logic            cmd_is_null
);
    logic [2:0]      pins_s;
    logic            ss_s, sck_s, mosi_s;
    logic            ss_d, sck_d;
    logic            ss_fall, ss_rise, sck_rise, sck_fall;
    logic            load, shift_en, out_en, miso_evt, frame_ok, take_cmd;
    logic [BITS-1:0] status, shreg, cmd_q;
    logic [CW-1:0]   cnt;
    logic            over, null_q;
    link_state_t     state_q, state_d;

    tss_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .INIT(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ss_n, sck, mosi}),
        .dout (pins_s)
    );

    assign ss_s   = pins_s[2];
    assign sck_s  = pins_s[1];
    assign mosi_s = pins_s[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            ss_d  <= ss_s;
            sck_d <= sck_s;
        end
    end

    assign ss_fall  = ss_d & ~ss_s;
    assign ss_rise  = ~ss_d & ss_s;
    assign sck_rise = ~sck_d & sck_s;
    assign sck_fall = sck_d & ~sck_s;

    tss_status_fmt #(.BITS(BITS)) u_fmt (
        .touch_det (touch_det),
        .wheel_type(wheel_type),
        .touch_pos (touch_pos),
        .status    (status)
    );

    assign load     = (state_q == ST_IDLE) && ss_fall;
    assign shift_en = (state_q == ST_SHIFT) && sck_rise && data_rdy;
    assign out_en   = (state_q == ST_SHIFT) && sck_fall && data_rdy;
    assign miso_evt = load | out_en;

    tss_shifter #(.BITS(BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(status),
        .shift_en(shift_en),
        .out_en  (out_en),
        .mosi_bit(mosi_s),
        .shreg   (shreg),
        .miso    (miso),
        .cnt     (cnt),
        .over    (over)
    );

    assign frame_ok = (cnt == CW'(BITS)) && !over;
    assign take_cmd = (state_q == ST_SHIFT) && ss_rise && frame_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (ss_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (ss_rise) state_d = frame_ok ? ST_COMMIT : ST_FAULT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Command latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            null_q <= 1'b0;
        end else if (take_cmd) begin
            cmd_q  <= shreg;
            null_q <= (shreg == '0);
        end
    end

    // Outputs
    always_comb begin
        frame_done  = 1'b0;
        frame_err   = 1'b0;
        cmd_is_null = 1'b0;
        unique case (state_q)
            ST_COMMIT: begin
                frame_done  = 1'b1;
                cmd_is_null = null_q;
            end
            ST_FAULT: frame_err = 1'b1;
            default: ;
        endcase
    end

    assign cmd_byte = cmd_q;
endmodule

// File: rtl/touch_spi_slave_chk.sv
module touch_spi_slave_chk #(
    parameter int BITS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            miso,
    input logic            miso_evt,
    input logic            ss_s,
    input logic [BITS-1:0] cmd_byte,
    input logic            frame_done,
    input logic            frame_err,
    input logic            cmd_is_null
);
    p_miso_on_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> $past(miso_evt));

    p_cmd_only_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_byte) |-> frame_done);

    p_done_on_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done || frame_err) |-> ss_s);

    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    p_null_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_is_null |-> (frame_done && cmd_byte == '0));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && frame_err));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind touch_spi_slave touch_spi_slave_chk #(.BITS(BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miso       (miso),
    .miso_evt   (miso_evt),
    .ss_s       (ss_s),
    .cmd_byte   (cmd_byte),
    .frame_done (frame_done),
    .frame_err  (frame_err),
    .cmd_is_null(cmd_is_null)
);

// File: tb/touch_spi_slave_tb.sv
module touch_spi_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n, sck, ss_n, mosi, data_rdy, touch_det, wheel_type;
    logic [6:0] touch_pos;
    logic       miso, frame_done, frame_err, cmd_is_null;
    logic [7:0] cmd_byte;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    touch_spi_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n), .mosi(mosi),
        .data_rdy(data_rdy), .touch_det(touch_det), .wheel_type(wheel_type),
        .touch_pos(touch_pos), .miso(miso), .cmd_byte(cmd_byte),
        .frame_done(frame_done), .frame_err(frame_err), .cmd_is_null(cmd_is_null)
    );

    // {touch, wheel, pos[6:0], cmd[7:0], expected status[7:0]}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 1'b0, 7'h55, 8'h00, 8'h00},
        {1'b0, 1'b1, 7'h7F, 8'hA5, 8'h40},
        {1'b1, 1'b0, 7'h00, 8'hFF, 8'h80},
        {1'b1, 1'b1, 7'h7F, 8'h3C, 8'hFF},
        {1'b1, 1'b0, 7'h2A, 8'h01, 8'hAA},
        {1'b0, 1'b0, 7'h7F, 8'h80, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] tx, input int nbits, input int blocked,
                             input int chg_at,
                             output logic [7:0] rx, output bit got_done, output bit got_err,
                             output logic [7:0] cmd_seen, output bit got_null,
                             output bit miso_ok);
        logic m;
        rx = '0; got_done = 0; got_err = 0; got_null = 0; cmd_seen = '0; miso_ok = 1;
        @(negedge clk);
        ss_n = 1'b0;
        wait_cyc(6);
        for (int b = 0; b < blocked; b++) begin
            data_rdy = 1'b0;
            mosi = 1'b1;
            wait_cyc(6);
            sck = 1'b1;
            wait_cyc(6);
            sck = 1'b0;
            wait_cyc(6);
            data_rdy = 1'b1;
        end
        for (int i = 0; i < nbits; i++) begin
            if (i == chg_at) begin
                touch_det = ~touch_det;
                touch_pos = ~touch_pos;
                wheel_type = ~wheel_type;
            end
            mosi = (i < 8) ? tx[7-i] : 1'b0;
            wait_cyc(6);
            if (i < 8) rx[7-i] = miso;
            m = miso;
            sck = 1'b1;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (miso !== m) miso_ok = 0;
            end
            sck = 1'b0;
        end
        wait_cyc(6);
        ss_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (frame_done) begin
                got_done = 1;
                cmd_seen = cmd_byte;
                got_null = cmd_is_null;
            end
            if (frame_err) got_err = 1;
        end
        wait_cyc(4);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx, cs, prev_cmd;
        bit d, e, nl, mok;

        rst_n = 1'b0; sck = 1'b0; ss_n = 1'b1; mosi = 1'b0; data_rdy = 1'b1;
        touch_det = 1'b0; wheel_type = 1'b0; touch_pos = '0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);

        // R11 reset state
        check(miso == 1'b0, "R11 miso", int'(miso), 0);
        check(cmd_byte == 8'h00, "R11 cmd_byte", int'(cmd_byte), 0);
        check({frame_done, frame_err, cmd_is_null} == 3'b000, "R11 flags",
              int'({frame_done, frame_err, cmd_is_null}), 0);

        // Table: R2 R3 R4 R9 R1 R10
        for (int v = 0; v < 6; v++) begin
            touch_det  = VEC[v][24];
            wheel_type = VEC[v][23];
            touch_pos  = VEC[v][22:16];
            run_frame(VEC[v][15:8], 8, 0, -1, rx, d, e, cs, nl, mok);
            check(rx == VEC[v][7:0], VEC[v][24] ? "R4 status touch" : "R3 status no-touch",
                  int'(rx), int'(VEC[v][7:0]));
            check(d && !e, "R10 done only", int'({d, e}), 2);
            check(cs == VEC[v][15:8], "R2 cmd_byte", int'(cs), int'(VEC[v][15:8]));
            check(nl == (VEC[v][15:8] == 8'h00), "R9 null flag", int'(nl),
                  int'(VEC[v][15:8] == 8'h00));
            check(mok, "R1 miso steady while sck high", int'(mok), 1);
        end

        // R5 mid-frame status change
        touch_det = 1'b1; wheel_type = 1'b0; touch_pos = 7'h15;
        run_frame(8'hC3, 8, 0, 3, rx, d, e, cs, nl, mok);
        check(rx == 8'h95, "R5 snapshot at select fall", int'(rx), 'h95);
        check(d && cs == 8'hC3, "R5 frame still valid", int'(cs), 'hC3);

        // R7 short frame
        touch_det = 1'b0; wheel_type = 1'b0; touch_pos = '0;
        prev_cmd = cmd_byte;
        run_frame(8'h77, 5, 0, -1, rx, d, e, cs, nl, mok);
        check(e && !d, "R7 short frame error", int'({d, e}), 1);
        check(cmd_byte == prev_cmd, "R7 cmd kept after short", int'(cmd_byte), int'(prev_cmd));

        // R7 long frame
        run_frame(8'h11, 9, 0, -1, rx, d, e, cs, nl, mok);
        check(e && !d, "R7 long frame error", int'({d, e}), 1);
        check(cmd_byte == prev_cmd, "R7 cmd kept after long", int'(cmd_byte), int'(prev_cmd));

        // R7 empty frame
        run_frame(8'h00, 0, 0, -1, rx, d, e, cs, nl, mok);
        check(e && !d, "R7 empty frame error", int'({d, e}), 1);

        // R8 blocked clock edges ignored
        run_frame(8'h5A, 8, 2, -1, rx, d, e, cs, nl, mok);
        check(d && !e, "R8 frame valid despite blocked edges", int'({d, e}), 2);
        check(cs == 8'h5A, "R8 cmd unaffected by blocked edges", int'(cs), 'h5A);
        check(rx == 8'h00, "R8 status unshifted", int'(rx), 0);

        // R6 cmd holds between frames
        wait_cyc(20);
        check(cmd_byte == 8'h5A, "R6 cmd_byte held", int'(cmd_byte), 'h5A);
        check(!frame_done && !frame_err, "R6 no pulse when idle",
              int'({frame_done, frame_err}), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule